// File: doc/BRIEF.md
# Vector Memory Address Sequencer

This block produces the stream of byte addresses that a vector load or store unit walks through. A single start pulse captures a mode, a base address, a stride and a requested element count. The block then issues one address per cycle on a valid/ready output stream, with each address tagged by its element number. Four modes share one datapath:

- consecutive 64-bit elements;
- a signed element stride;
- gather/scatter, which adds each entry of an incoming index stream to the base;
- index-vector creation, which puts multiples of a scalar on the output in place of addresses.

The output register holds its contents while the consumer stalls. The consumer may lower `out_ready` in any cycle, and a new element enters the register only in a cycle when it is empty or its current element is being taken. In gather mode, an index is taken (`idx_valid && idx_ready`) in the same cycle as the element it produces enters the output register. The producer may hold `idx_valid` low for any number of cycles. A `done` pulse marks the end of each operation. While an operation runs, further start pulses are ignored.

Top module: `vec_addr_seq`

## Requirements
- R1: With `mode` = 0 (consecutive), element i carries `base + 8*i` on `out_addr`.
- R2: With `mode` = 1 (strided), element i carries `base + 8*stride*i`, where `stride` is a two's-complement signed value.
- R3: With `mode` = 2 (gather), element i carries `base + idx_i`, where idx_i is the i-th word accepted on the index stream. Indexes are taken in order, exactly one per element, and `idx_ready` is never high in any other mode.
- R4: With `mode` = 3 (index creation), element i carries `stride * i` on `out_addr`.
- R5: An operation emits min(`vlen`, 64) elements, numbered 0 upward in order on `out_elem`. A `vlen` above 64 is treated as 64.
- R6: A start with `vlen` = 0 emits nothing, keeps `busy` low and pulses `done` in the cycle after the start edge.
- R7: The first element is valid in the second cycle after the start edge. While `out_ready` stays high (and, in gather mode, `idx_valid` stays high), one element is delivered every cycle.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_addr` and `out_elem` hold their values into the next cycle.
- R9: `done` is a one-cycle pulse in the cycle after the last element's handshake. In that cycle `busy` and `out_valid` are low.
- R10: A start pulse while `busy` is high has no effect on the running operation's addresses, count or element numbers.
- R11: All address and index-creation arithmetic wraps modulo 2^32.
- R12: During and after reset, `out_valid`, `busy`, `done` and `idx_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, taken only when idle |
| mode | input | 2 | 0 consecutive, 1 strided, 2 gather, 3 index creation |
| base | input | 32 | Base byte address |
| stride | input | 32 | Signed element stride, or the scalar in index creation |
| vlen | input | 7 | Requested element count (capped at 64) |
| idx_valid | input | 1 | Index stream word valid |
| idx_ready | output | 1 | Index word taken this cycle |
| idx_data | input | 32 | Index stream byte offset |
| out_valid | output | 1 | Output element valid |
| out_ready | input | 1 | Consumer accepts the element |
| out_addr | output | 32 | Address, or generated index value |
| out_elem | output | 6 | Element number |
| busy | output | 1 | Operation in progress |
| done | output | 1 | End-of-operation pulse |

## Verification
The assertions assume that `mode`, `base` and `stride` are sampled only on an accepted start. They also assume that the consumer never takes an element while `out_valid` is low, and that the index producer keeps `idx_data` meaningful whenever it raises `idx_valid`. The stimulus changes inputs only at falling edges. It offers index words in order, recomputing each word from the count of completed index handshakes. It deliberately drives start pulses with different parameters during a run, so that the parameters captured at start must govern every element. Back-pressure comes from fixed periodic `out_ready` and `idx_valid` patterns, so every stall and resume lands on a known cycle.

// File: rtl/vag_pkg.sv
package vag_pkg;
  typedef enum logic [1:0] {
    MODE_UNIT   = 2'd0,
    MODE_STRIDE = 2'd1,
    MODE_GATHER = 2'd2,
    MODE_IOTA   = 2'd3
  } vag_mode_e;
endpackage

// File: rtl/vag_ctrl.sv
// Element bookkeeping: operation length, issue and retire counts, done pulse.
module vag_ctrl #(
  parameter int MAXVL = 64,
  parameter int VLW   = 7,
  parameter int EIW   = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [VLW-1:0] vlen,
  input  logic           issue,
  input  logic           retire,
  output logic           accept,
  output logic           busy,
  output logic           pending,
  output logic [EIW-1:0] issue_idx,
  output logic           done
);
  localparam logic [VLW-1:0] MAX_LEN = VLW'(MAXVL);
  localparam logic [VLW-1:0] ONE     = VLW'(1);

  logic           busy_q, done_q;
  logic [VLW-1:0] len_q, iss_q, ret_q, eff_len;

  assign eff_len   = (vlen > MAX_LEN) ? MAX_LEN : vlen;
  assign accept    = start && !busy_q;
  assign busy      = busy_q;
  assign done      = done_q;
  assign pending   = busy_q && (iss_q != len_q);
  assign issue_idx = iss_q[EIW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      len_q  <= '0;
      iss_q  <= '0;
      ret_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        len_q <= eff_len;
        iss_q <= '0;
        ret_q <= '0;
        if (eff_len == '0) done_q <= 1'b1;
        else               busy_q <= 1'b1;
      end else if (busy_q) begin
        if (issue)  iss_q <= iss_q + ONE;
        if (retire) begin
          ret_q <= ret_q + ONE;
          if (ret_q == len_q - ONE) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  p_issue_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> pending);
  p_retire_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ret_q <= iss_q);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy_q);
  p_len_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start) |=> $stable(len_q));
endmodule

// File: rtl/vag_addr_gen.sv
// Captures the operation parameters and walks a running accumulator.
module vag_addr_gen
  import vag_pkg::*;
#(
  parameter int AW         = 32,
  parameter int ELEM_SHIFT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  vag_mode_e     mode_in,
  input  logic [AW-1:0] base_in,
  input  logic [AW-1:0] stride_in,
  input  logic          adv,
  input  logic [AW-1:0] idx_data,
  output vag_mode_e     mode_q,
  output logic [AW-1:0] value
);
  localparam logic [AW-1:0] UNIT_STEP = AW'(1) << ELEM_SHIFT;

  logic [AW-1:0] base_q, acc_q, step_q, step_d, acc_init;

  always_comb begin
    step_d   = '0;
    acc_init = base_in;
    case (mode_in)
      MODE_UNIT:   step_d = UNIT_STEP;
      MODE_STRIDE: step_d = stride_in << ELEM_SHIFT;
      MODE_GATHER: step_d = '0;
      MODE_IOTA: begin
        step_d   = stride_in;
        acc_init = '0;
      end
      default:     step_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_UNIT;
      base_q <= '0;
      acc_q  <= '0;
      step_q <= '0;
    end else if (load) begin
      mode_q <= mode_in;
      base_q <= base_in;
      acc_q  <= acc_init;
      step_q <= step_d;
    end else if (adv) begin
      acc_q  <= acc_q + step_q;
    end
  end

  assign value = (mode_q == MODE_GATHER) ? base_q + idx_data : acc_q;

  p_acc_steps_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && adv) |=> (acc_q == $past(acc_q) + $past(step_q)));
endmodule

// File: rtl/vag_out_stage.sv
// Single output register with valid/ready hold.
module vag_out_stage #(
  parameter int AW  = 32,
  parameter int EIW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [AW-1:0]  d_addr,
  input  logic [EIW-1:0] d_elem,
  input  logic           out_ready,
  output logic           can_load,
  output logic           out_valid,
  output logic [AW-1:0]  out_addr,
  output logic [EIW-1:0] out_elem
);
  logic valid_q;

  assign out_valid = valid_q;
  assign can_load  = !valid_q || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      out_addr <= '0;
      out_elem <= '0;
    end else if (load) begin
      valid_q  <= 1'b1;
      out_addr <= d_addr;
      out_elem <= d_elem;
    end else if (out_ready) begin
      valid_q  <= 1'b0;
    end
  end

  p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_elem)));
  p_load_room_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> can_load);
endmodule

// File: rtl/vec_addr_seq.sv
module vec_addr_seq
  import vag_pkg::*;
#(
  parameter int AW         = 32,
  parameter int MAXVL      = 64,
  parameter int ELEM_SHIFT = 3,
  parameter int VLW        = $clog2(MAXVL + 1),
  parameter int EIW        = $clog2(MAXVL)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [1:0]     mode,
  input  logic [AW-1:0]  base,
  input  logic [AW-1:0]  stride,
  input  logic [VLW-1:0] vlen,
  input  logic           idx_valid,
  output logic           idx_ready,
  input  logic [AW-1:0]  idx_data,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [AW-1:0]  out_addr,
  output logic [EIW-1:0] out_elem,
  output logic           busy,
  output logic           done
);
  logic           accept, pending, can_load, issue, retire, gather;
  logic [EIW-1:0] issue_idx;
  logic [AW-1:0]  value;
  vag_mode_e      mode_q;

  assign gather    = (mode_q == MODE_GATHER);
  assign issue     = pending && can_load && (!gather || idx_valid);
  assign idx_ready = pending && can_load && gather;
  assign retire    = out_valid && out_ready;

  vag_ctrl #(.MAXVL(MAXVL), .VLW(VLW), .EIW(EIW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .vlen(vlen),
    .issue(issue), .retire(retire), .accept(accept), .busy(busy),
    .pending(pending), .issue_idx(issue_idx), .done(done)
  );

  vag_addr_gen #(.AW(AW), .ELEM_SHIFT(ELEM_SHIFT)) u_gen (
    .clk(clk), .rst_n(rst_n), .load(accept), .mode_in(vag_mode_e'(mode)),
    .base_in(base), .stride_in(stride), .adv(issue), .idx_data(idx_data),
    .mode_q(mode_q), .value(value)
  );

  vag_out_stage #(.AW(AW), .EIW(EIW)) u_out (
    .clk(clk), .rst_n(rst_n), .load(issue), .d_addr(value), .d_elem(issue_idx),
    .out_ready(out_ready), .can_load(can_load), .out_valid(out_valid),
    .out_addr(out_addr), .out_elem(out_elem)
  );

  p_idx_gather_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    idx_ready |-> (gather && busy));
  p_idx_feeds_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_valid && idx_ready) |=> out_valid);
  p_first_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !gather && vlen != '0) |=> ##1 out_valid);
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !idx_ready);
endmodule

// File: tb/vec_addr_seq_test.sv
module vec_addr_seq_test;
  typedef struct packed {
    logic [1:0]  mode;
    logic [31:0] base;
    logic [31:0] stride;
    logic [6:0]  vlen;
    logic        rdy_alt;
    logic        idx_alt;
    logic        noise;
  } row_t;

  localparam row_t ROWS [10] = '{
    '{2'd0, 32'h0000_1000, 32'h0000_0000, 7'd5,   1'b0, 1'b0, 1'b0},
    '{2'd1, 32'h0000_2000, 32'h0000_0003, 7'd6,   1'b1, 1'b0, 1'b1},
    '{2'd1, 32'h0000_0100, 32'hFFFF_FFFE, 7'd4,   1'b0, 1'b0, 1'b0},
    '{2'd2, 32'h0000_4000, 32'h0000_0000, 7'd7,   1'b0, 1'b0, 1'b1},
    '{2'd2, 32'h0000_0010, 32'h0000_0000, 7'd5,   1'b1, 1'b1, 1'b0},
    '{2'd3, 32'h0000_0000, 32'h0000_0005, 7'd8,   1'b0, 1'b0, 1'b0},
    '{2'd0, 32'hFFFF_FFF0, 32'h0000_0000, 7'd4,   1'b0, 1'b0, 1'b0},
    '{2'd3, 32'h0000_0000, 32'h4000_0000, 7'd6,   1'b1, 1'b0, 1'b0},
    '{2'd0, 32'h0000_8000, 32'h0000_0000, 7'd64,  1'b0, 1'b0, 1'b0},
    '{2'd1, 32'h0000_0000, 32'h0000_0001, 7'd100, 1'b0, 1'b0, 1'b0}
  };

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0]  mode = '0;
  logic [31:0] base = '0, stride = '0, idx_data = '0;
  logic [6:0]  vlen = '0;
  logic        idx_valid = 1'b0, out_ready = 1'b0;
  logic        idx_ready, out_valid, busy, done;
  logic [31:0] out_addr;
  logic [5:0]  out_elem;
  int total = 0, fails = 0;

  always #5 clk = ~clk;

  vec_addr_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .base(base),
    .stride(stride), .vlen(vlen), .idx_valid(idx_valid), .idx_ready(idx_ready),
    .idx_data(idx_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_elem(out_elem), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] idx_fn(input int k);
    return 32'((k % 3) * 200 + k * 8);
  endfunction

  function automatic logic [31:0] exp_val(input row_t r, input int n);
    case (r.mode)
      2'd0:    return r.base + 32'(n) * 32'd8;
      2'd1:    return r.base + (r.stride << 3) * 32'(n);
      2'd2:    return r.base + idx_fn(n);
      default: return r.stride * 32'(n);
    endcase
  endfunction

  task automatic run_row(input row_t r, input int ri);
    int len, n, k, first_c, errs;
    bit done_seen, held, thr_ok;
    logic [31:0] held_a;
    logic [5:0]  held_e;
    string tag;
    len = (r.vlen > 7'd64) ? 64 : int'(r.vlen);
    n = 0; k = 0; first_c = -1; errs = 0;
    done_seen = 0; held = 0; thr_ok = 1;
    case (r.mode)
      2'd0: tag = "R1";
      2'd1: tag = "R2";
      2'd2: tag = "R3";
      default: tag = "R4";
    endcase
    if (ri == 6 || ri == 7) tag = "R11";
    @(negedge clk);
    start = 1'b1; mode = r.mode; base = r.base; stride = r.stride; vlen = r.vlen;
    out_ready = 1'b0; idx_valid = 1'b0;
    for (int c = 0; c < 600 && !done_seen; c++) begin
      @(negedge clk);
      start = r.noise && (n < len);
      mode = ~r.mode; base = r.base ^ 32'h5A5A_0000; stride = r.stride + 32'd1; vlen = 7'd3;
      out_ready = r.rdy_alt ? (c % 3 != 1) : 1'b1;
      idx_valid = (r.mode == 2'd2) && (r.idx_alt ? (c % 2 == 0) : 1'b1);
      idx_data = idx_fn(k);
      #1;
      if (held) begin
        check(out_valid && out_addr == held_a && out_elem == held_e, "R8", out_addr, held_a);
        held = 0;
      end
      if (done) begin
        done_seen = 1;
        check(n == len && !busy && !out_valid, "R9", 32'(n), 32'(len));
      end
      if (out_valid && first_c < 0) first_c = c;
      if (out_valid && out_ready) begin
        if (out_addr != exp_val(r, n)) errs++;
        check(out_addr == exp_val(r, n), tag, out_addr, exp_val(r, n));
        check(out_elem == 6'(n), "R5", 32'(out_elem), 32'(n));
        if (c != n + 1) thr_ok = 0;
        n++;
      end else if (out_valid) begin
        held = 1; held_a = out_addr; held_e = out_elem;
      end
      if (idx_valid && idx_ready) k++;
    end
    @(negedge clk);
    start = 1'b0; out_ready = 1'b0; idx_valid = 1'b0;
    check(done_seen && n == len, "R5", 32'(n), 32'(len));
    if (r.mode == 2'd2) check(k == len, "R3", 32'(k), 32'(len));
    else check(!idx_ready, "R3", 32'(idx_ready), 32'd0);
    if (!r.rdy_alt && !r.idx_alt) begin
      check(first_c == 1, "R7", 32'(first_c), 32'd1);
      check(thr_ok, "R7", 32'(thr_ok), 32'd1);
    end
    if (r.noise) check(errs == 0 && n == len, "R10", 32'(errs), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #1;
    check(!out_valid && !busy && !done && !idx_ready, "R12", {28'd0, out_valid, busy, done, idx_ready}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(!out_valid && !busy && !done && !idx_ready, "R12", {28'd0, out_valid, busy, done, idx_ready}, 32'd0);

    for (int i = 0; i < 10; i++) run_row(ROWS[i], i);

    // R6: zero-length operation
    @(negedge clk);
    start = 1'b1; mode = 2'd0; base = 32'h100; vlen = 7'd0; out_ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    check(done && !busy && !out_valid, "R6", {29'd0, done, busy, out_valid}, 32'd4);
    @(negedge clk);
    #1;
    check(!done && !busy && !out_valid, "R6", {29'd0, done, busy, out_valid}, 32'd0);

    // R12: reset in the middle of an operation
    @(negedge clk);
    start = 1'b1; mode = 2'd2; base = 32'h40; vlen = 7'd10; idx_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(!out_valid && !busy && !done && !idx_ready, "R12", {28'd0, out_valid, busy, done, idx_ready}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1; idx_valid = 1'b0;
    @(negedge clk);
    #1;
    check(!out_valid && !busy && !done, "R12", {29'd0, out_valid, busy, done}, 32'd0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule